// File: doc/BRIEF.md
# Burst Column Order Generator

This block turns a column access command into the list of low column offsets that the data beats of the burst visit. At command time it captures the three low start-column bits, the read or write direction, the burst type (nibble-sequential or interleaved), and the two-bit burst length mode. In the on-the-fly mode, an address bit sampled with the command picks the length. After that, each pulse on the beat-enable input releases one offset. The offset comes with a valid strobe, and the final beat is flagged.

The block sits between the command decoder and the data path of a memory controller. The data path uses the offsets to order or place the beats of a full eight-beat burst or a four-beat chopped burst. The block also reports the effective length of the accepted burst, 4 or 8. A command that arrives while a burst is still running is refused and flagged. A command that names the reserved length mode is refused and flagged in the same way.

Top module: `burst_order_gen`

## Requirements
- R1: After reset, `beat_valid`, `beat_last` and `cmd_drop_err` are 0 and `burst_len` is 0.
- R2: The length mode `len_mode` is decoded at command acceptance: 2'b00 gives 8 beats and 2'b10 gives 4 beats. From the cycle after acceptance, `burst_len` shows the effective length (8 or 4) and holds it until the next accepted command.
- R3: With `len_mode` = 2'b01 (on-the-fly), `chop_n` = 1 selects 8 beats and `chop_n` = 0 selects 4 beats.
- R4: For a read with `interleave` = 0, beat i has offset {s[2] XOR i[2], (s[1:0] + i[1:0]) mod 4}, where s is `start_col`. The count wraps inside the 4-column group, so start 1 gives 1,2,3,0,5,6,7,4.
- R5: For a read with `interleave` = 1, beat i has offset s XOR i.
- R6: For an 8-beat write, the offsets are 0,1,2,...,7 whatever the values of `start_col` and `interleave`.
- R7: For a 4-beat write, `start_col[1:0]` is ignored. With `start_col[2]` = 0 the offsets are 0,1,2,3; with `start_col[2]` = 1 they are 4,5,6,7.
- R8: Each `beat_en` pulse during a burst gives exactly one `beat_valid` cycle, one clock later. `beat_last` is raised with the 4th beat of a 4-beat burst and with the 8th beat of an 8-beat burst, and no further beats follow.
- R9: A `cmd_valid` that arrives while a burst is in progress is dropped. `cmd_drop_err` is 1 in the next cycle only, and the running burst continues unchanged.
- R10: A `cmd_valid` with `len_mode` = 2'b11 is dropped. `cmd_drop_err` is 1 in the next cycle, `burst_len` keeps its value and no beats are produced.
- R11: A `beat_en` pulse while no burst is in progress produces no `beat_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Column command presented this cycle |
| cmd_is_write | input | 1 | 1 for write, 0 for read |
| interleave | input | 1 | Burst type: 0 sequential, 1 interleaved |
| len_mode | input | 2 | Length mode: 00 fixed 8, 01 on-the-fly, 10 fixed 4, 11 reserved |
| chop_n | input | 1 | On-the-fly length select: 1 gives 8 beats, 0 gives 4 |
| start_col | input | 3 | Low start column bits |
| beat_en | input | 1 | Request for the next beat offset |
| beat_valid | output | 1 | Offset valid this cycle |
| beat_offset | output | 3 | Column offset of the beat |
| beat_last | output | 1 | Final beat of the burst |
| burst_len | output | 4 | Effective length of the last accepted burst (4 or 8, 0 after reset) |
| cmd_drop_err | output | 1 | One-cycle flag for a refused command |

## Verification
Every output is a single register stage. A beat requested on one rising edge appears on the ports after that edge. The effective length and the drop flag both appear one edge after the command. The bench drives inputs on the falling edge, so each result is read on the next falling edge. A driver task queues the expected offsets and last flags for each burst, and a monitor pops one entry each time the strobe is seen. Any strobe seen with an empty queue is an error, which also covers the refused and idle cases. Beat requests are sent both back to back and with gaps, to show that the output follows the requests and not the cycle count.

// File: rtl/bog_pkg.sv
package bog_pkg;
    localparam int OFS_W   = 3;
    localparam int BEATS8  = 1 << OFS_W;
    localparam int BEATS4  = BEATS8 / 2;
    localparam int LEN_W   = OFS_W + 1;

    typedef enum logic [1:0] {
        LEN_FIX8 = 2'b00,
        LEN_OTF  = 2'b01,
        LEN_FIX4 = 2'b10,
        LEN_RSVD = 2'b11
    } len_mode_e;

    typedef struct packed {
        logic             busy;
        logic             wr;
        logic             ilv;
        logic             bc4;
        logic [OFS_W-1:0] start;
        logic [OFS_W-1:0] idx;
        logic             vld;
        logic [OFS_W-1:0] off;
        logic             last;
        logic [LEN_W-1:0] blen;
        logic             err;
    } gen_state_t;
endpackage

// File: rtl/bog_len_decode.sv
module bog_len_decode
    import bog_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       chop_n,
    output logic       legal,
    output logic       short4
);
    always_comb begin
        legal  = 1'b1;
        short4 = 1'b0;
        unique case (len_mode_e'(mode))
            LEN_FIX8: short4 = 1'b0;
            LEN_OTF:  short4 = ~chop_n;
            LEN_FIX4: short4 = 1'b1;
            default:  legal  = 1'b0;
        endcase
    end
endmodule

// File: rtl/bog_beat_order.sv
module bog_beat_order #(
    parameter int W = 3
) (
    input  logic [W-1:0] start,
    input  logic [W-1:0] idx,
    input  logic         wr,
    input  logic         ilv,
    input  logic         short4,
    output logic [W-1:0] off
);
    localparam int LO = W - 1;

    logic [W-1:0] seq_off;
    logic [W-1:0] wr_off;

    always_comb begin
        seq_off[W-1]    = start[W-1] ^ idx[W-1];
        seq_off[LO-1:0] = start[LO-1:0] + idx[LO-1:0];
        wr_off          = short4 ? {start[W-1], idx[LO-1:0]} : idx;
        if (wr)
            off = wr_off;
        else if (ilv)
            off = start ^ idx;
        else
            off = seq_off;
    end
endmodule

// File: rtl/burst_order_gen.sv
module burst_order_gen
    import bog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_is_write,
    input  logic             interleave,
    input  logic [1:0]       len_mode,
    input  logic             chop_n,
    input  logic [OFS_W-1:0] start_col,
    input  logic             beat_en,
    output logic             beat_valid,
    output logic [OFS_W-1:0] beat_offset,
    output logic             beat_last,
    output logic [LEN_W-1:0] burst_len,
    output logic             cmd_drop_err
);
    localparam logic [OFS_W-1:0] IDX_END8 = OFS_W'(BEATS8 - 1);
    localparam logic [OFS_W-1:0] IDX_END4 = OFS_W'(BEATS4 - 1);

    gen_state_t st_q, st_d;
    logic             mode_ok;
    logic             mode_short;
    logic [OFS_W-1:0] next_off;
    logic             final_beat;

    bog_len_decode u_dec (
        .mode   (len_mode),
        .chop_n (chop_n),
        .legal  (mode_ok),
        .short4 (mode_short)
    );

    bog_beat_order #(.W(OFS_W)) u_ord (
        .start  (st_q.start),
        .idx    (st_q.idx),
        .wr     (st_q.wr),
        .ilv    (st_q.ilv),
        .short4 (st_q.bc4),
        .off    (next_off)
    );

    always_comb begin
        st_d       = st_q;
        st_d.vld   = 1'b0;
        st_d.last  = 1'b0;
        st_d.err   = 1'b0;
        final_beat = st_q.bc4 ? (st_q.idx == IDX_END4) : (st_q.idx == IDX_END8);

        if (cmd_valid && (st_q.busy || !mode_ok))
            st_d.err = 1'b1;

        if (st_q.busy && beat_en) begin
            st_d.vld  = 1'b1;
            st_d.off  = next_off;
            st_d.last = final_beat;
            st_d.idx  = st_q.idx + 1'b1;
            if (final_beat)
                st_d.busy = 1'b0;
        end

        if (cmd_valid && !st_q.busy && mode_ok) begin
            st_d.busy  = 1'b1;
            st_d.wr    = cmd_is_write;
            st_d.ilv   = interleave;
            st_d.bc4   = mode_short;
            st_d.start = start_col;
            st_d.idx   = '0;
            st_d.blen  = mode_short ? LEN_W'(BEATS4) : LEN_W'(BEATS8);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign beat_valid   = st_q.vld;
    assign beat_offset  = st_q.off;
    assign beat_last    = st_q.last;
    assign burst_len    = st_q.blen;
    assign cmd_drop_err = st_q.err;
endmodule

// File: rtl/bog_chk.sv
module bog_chk
    import bog_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             beat_en,
    input logic             beat_valid,
    input logic             beat_last,
    input logic [LEN_W-1:0] burst_len,
    input logic             cmd_drop_err
);
    logic [LEN_W-1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            seen_q <= '0;
        else if (beat_valid && beat_last)
            seen_q <= '0;
        else if (beat_valid)
            seen_q <= seen_q + 1'b1;
    end

    a_r8_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_valid);

    a_r8_valid_from_request: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> $past(beat_en));

    a_r8_last_at_length: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_last) |-> (seen_q == burst_len - 1'b1));

    a_r2_length_values: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_len == 4'd0) || (burst_len == 4'd4) || (burst_len == 4'd8));

    a_r9_drop_from_command: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_drop_err |-> $past(cmd_valid));
endmodule

bind burst_order_gen bog_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .beat_en      (beat_en),
    .beat_valid   (beat_valid),
    .beat_last    (beat_last),
    .burst_len    (burst_len),
    .cmd_drop_err (cmd_drop_err)
);

// File: tb/sim_burst_order_gen.sv
module sim_burst_order_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_is_write = 1'b0;
    logic       interleave = 1'b0;
    logic [1:0] len_mode = 2'b00;
    logic       chop_n = 1'b0;
    logic [2:0] start_col = 3'd0;
    logic       beat_en = 1'b0;
    logic       beat_valid;
    logic [2:0] beat_offset;
    logic       beat_last;
    logic [3:0] burst_len;
    logic       cmd_drop_err;

    int checks = 0;
    int errors = 0;
    logic [3:0] exp_q[$];
    string cur_req = "R4";

    always #2 clk = ~clk;

    burst_order_gen u0 (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [2:0] model(input bit wr, input bit ilv, input bit b4,
                                         input logic [2:0] s, input logic [2:0] i);
        if (wr) return b4 ? {s[2], i[1:0]} : i;
        if (ilv) return s ^ i;
        return {s[2] ^ i[2], 2'(s[1:0] + i[1:0])};
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && beat_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11", beat_offset, -1);
            end else begin
                logic [3:0] e;
                e = exp_q.pop_front();
                chk({beat_last, beat_offset} == e, cur_req, {beat_last, beat_offset}, e);
            end
        end
    end

    task automatic beat(input int gap);
        @(negedge clk) beat_en = 1'b1;
        @(negedge clk) beat_en = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic issue(input bit wr, input bit ilv, input logic [1:0] m,
                         input bit c, input logic [2:0] s);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_is_write = wr; interleave = ilv;
        len_mode = m; chop_n = c; start_col = s;
        @(negedge clk);
        cmd_valid = 1'b0; start_col = ~s; chop_n = ~c;
    endtask

    task automatic run(input string req, input bit wr, input bit ilv,
                       input logic [1:0] m, input bit c, input logic [2:0] s, input int gap);
        bit b4;
        b4 = (m == 2'b10) || (m == 2'b01 && !c);
        cur_req = req;
        issue(wr, ilv, m, c, s);
        chk(burst_len == (b4 ? 4'd4 : 4'd8), (m == 2'b01) ? "R3" : "R2", burst_len, b4 ? 4 : 8);
        for (int i = 0; i < (b4 ? 4 : 8); i++)
            exp_q.push_back({(i == (b4 ? 3 : 7)), model(wr, ilv, b4, s, 3'(i))});
        for (int i = 0; i < (b4 ? 4 : 8); i++) beat(gap);
        beat(0); // R8: extra request after the last beat yields nothing
        chk(exp_q.size() == 0, "R8", exp_q.size(), 0);
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                chk(1'b0, "watchdog", 0, 1);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!beat_valid && !beat_last && !cmd_drop_err, "R1", beat_valid, 0);
        chk(burst_len == 4'd0, "R1", burst_len, 0);
        rst_n = 1'b1;

        // R11 beat request while idle
        cur_req = "R11";
        beat(2);

        // R4 sequential reads, wrap inside nibble
        run("R4", 0, 0, 2'b00, 0, 3'd1, 0);
        run("R4", 0, 0, 2'b00, 0, 3'd6, 1);
        run("R4", 0, 0, 2'b10, 0, 3'd5, 0);
        // R5 interleaved reads
        run("R5", 0, 1, 2'b00, 0, 3'd3, 0);
        run("R5", 0, 1, 2'b01, 0, 3'd6, 2);
        // R3 on-the-fly length
        run("R3", 0, 0, 2'b01, 1, 3'd2, 0);
        run("R3", 0, 1, 2'b01, 0, 3'd1, 0);
        // R6 8-beat writes ignore start and type
        run("R6", 1, 0, 2'b00, 0, 3'd5, 0);
        run("R6", 1, 1, 2'b01, 1, 3'd7, 1);
        // R7 4-beat writes
        run("R7", 1, 0, 2'b10, 0, 3'd3, 0);
        run("R7", 1, 1, 2'b01, 0, 3'd6, 0);

        // R9 command during a burst
        cur_req = "R9";
        issue(0, 0, 2'b00, 0, 3'd2);
        for (int i = 0; i < 8; i++) exp_q.push_back({(i == 7), model(0, 0, 0, 3'd2, 3'(i))});
        beat(0); beat(0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_is_write = 1'b1; len_mode = 2'b10; start_col = 3'd4;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_drop_err == 1'b1, "R9", cmd_drop_err, 1);
        @(negedge clk);
        chk(cmd_drop_err == 1'b0, "R9", cmd_drop_err, 0);
        chk(burst_len == 4'd8, "R9", burst_len, 8);
        for (int i = 0; i < 6; i++) beat(0);
        beat(0);
        chk(exp_q.size() == 0, "R9", exp_q.size(), 0);

        // R10 reserved mode
        run("R10", 0, 0, 2'b10, 0, 3'd0, 0);
        cur_req = "R10";
        @(negedge clk);
        cmd_valid = 1'b1; len_mode = 2'b11; cmd_is_write = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0; len_mode = 2'b00;
        chk(cmd_drop_err == 1'b1, "R10", cmd_drop_err, 1);
        chk(burst_len == 4'd4, "R10", burst_len, 4);
        beat(0); beat(1);

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule